// File: doc/BRIEF.md
# Serial Synthesizer Configuration Loader

This block takes a three-pin serial stream (a data line, a bit clock and a load strobe) from a controller and turns it into the divide settings of a frequency synthesizer. It runs in the system clock domain: all three pins pass through synchronizer flops. A rising bit-clock edge is detected in that domain and shifts one data bit into a shift register, most significant bit first. A rising edge of the load strobe then copies the register into one of two configuration latches.

The last bit shifted in is a routing flag, and it picks the destination latch.

- With the flag at 1, the word is a reference word. Its first bit selects the prescaler modulus, and the next 14 bits give the reference divide ratio.
- With the flag at 0, the word is a divider word. It carries an 11-bit main counter ratio followed by a 7-bit swallow count.

Every load is range-checked. A reference ratio below 8 or a main ratio below 16 is refused: the latch keeps its old contents and a sticky error flag is raised.

Top module: `synth_prog_if`

## Requirements
- R1: Each rising edge of the synchronized bit clock shifts the data pin in at the low end of a 19-bit register, so the bit sent first ends up as the most significant bit. If more than 19 bits are sent before a load, the earliest bits drop out and have no effect.
- R2: A load whose last bit is 1 is a reference word of 16 bits. Its first bit drives pre_sel_o, where 0 means the 128/129 modulus and 1 means the 64/65 modulus. The following 14 bits, most significant first, drive ref_ratio_o.
- R3: A load whose last bit is 0 is a divider word of 19 bits. The first 11 bits, most significant first, drive main_cnt_o, and the next 7 bits drive swallow_o.
- R4: A reference ratio of 8 or more is accepted. A ratio below 8 leaves ref_ratio_o and pre_sel_o unchanged and sets cfg_err_o.
- R5: A main ratio of 16 or more is accepted together with any swallow value from 0 to 127. A main ratio below 16 leaves main_cnt_o and swallow_o unchanged and sets cfg_err_o.
- R6: Once set, cfg_err_o stays at 1 through later legal loads, until the next reset.
- R7: Each low-to-high transition of the load strobe causes exactly one transfer. Bits shifted while the strobe stays high change no output until the next rising edge of the strobe. A load into one latch leaves the other latch unchanged.
- R8: Reset gives ref_ratio_o=8, pre_sel_o=0, main_cnt_o=16, swallow_o=0 and cfg_err_o=0.
- R9: The outputs change only as the result of a load. Toggling the bit clock and data pin while the strobe is low leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_data_i | input | 1 | Serial data pin |
| ser_clk_i | input | 1 | Serial bit clock pin; a rising edge shifts one bit |
| ser_le_i | input | 1 | Load strobe pin; a rising edge transfers the register |
| ref_ratio_o | output | 14 | Latched reference divide ratio |
| pre_sel_o | output | 1 | Latched prescaler select (0: 128/129, 1: 64/65) |
| main_cnt_o | output | 11 | Latched main counter ratio |
| swallow_o | output | 7 | Latched swallow count |
| cfg_err_o | output | 1 | Sticky flag for a refused out-of-range load |

## Verification
Random reference and divider words are interleaved so that a swapped routing flag or a misplaced field shows up on the other latch's outputs. Some of these words carry ratios just below the legal floor, which separates refusal and sticky flagging from plain loading. Directed cases check the following:
- exact floor values (7 against 8, and 15 against 16), which expose off-by-one comparisons;
- words preceded by extra junk bits, which show whether only the last 19 bits count;
- a strobe held high while a new word is shifted in, which tells a level-triggered load from an edge-triggered one;
- a final reset, which shows that the error flag clears.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic {
    DEST_DIV = 1'b0,
    DEST_REF = 1'b1
  } dest_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sp_shifter.sv
module sp_shifter #(
  parameter int unsigned WORD_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_s_i,
  input  logic              data_s_i,
  input  logic              le_s_i,
  output logic [WORD_W-1:0] word_o,
  output logic              le_rise_o
);
  logic              bclk_prev_q, bclk_prev_d;
  logic              le_prev_q, le_prev_d;
  logic [WORD_W-1:0] sr_q, sr_d;
  logic              bclk_rise;
  logic              sr_en;

  assign bclk_rise = bclk_s_i & ~bclk_prev_q;
  assign le_rise_o = le_s_i & ~le_prev_q;
  assign sr_en     = bclk_rise;

  always_comb begin
    bclk_prev_d = bclk_s_i;
    le_prev_d   = le_s_i;
    sr_d        = sr_q;
    if (sr_en) sr_d = {sr_q[WORD_W-2:0], data_s_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_prev_q <= 1'b0;
      le_prev_q   <= 1'b1;
      sr_q        <= '0;
    end else begin
      bclk_prev_q <= bclk_prev_d;
      le_prev_q   <= le_prev_d;
      if (sr_en) sr_q <= sr_d;
    end
  end

  assign word_o = sr_q;

  // R1: register moves only on a detected bit-clock edge
  a_r1_shift_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bclk_s_i |=> $stable(sr_q));
  // R7: one strobe edge gives a single transfer request
  a_r7_single_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_rise_o |=> !le_rise_o);
endmodule

// File: rtl/sp_cfg_bank.sv
module sp_cfg_bank #(
  parameter int unsigned WORD_W = 19,
  parameter int unsigned R_W = 14,
  parameter int unsigned N_W = 11,
  parameter int unsigned A_W = 7,
  parameter int unsigned R_MIN = 8,
  parameter int unsigned N_MIN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              le_rise_i,
  output logic [R_W-1:0]    ref_ratio_o,
  output logic              pre_sel_o,
  output logic [N_W-1:0]    main_cnt_o,
  output logic [A_W-1:0]    swallow_o,
  output logic              cfg_err_o
);
  import sp_pkg::*;

  localparam logic [R_W-1:0] R_MIN_V = R_W'(R_MIN);
  localparam logic [N_W-1:0] N_MIN_V = N_W'(N_MIN);

  logic [R_W-1:0] ref_q, ref_d;
  logic           sw_q, sw_d;
  logic [N_W-1:0] n_q, n_d;
  logic [A_W-1:0] a_q, a_d;
  logic           err_q, err_d;

  dest_e          dest;
  logic [R_W-1:0] fld_ref;
  logic           fld_sw;
  logic [N_W-1:0] fld_n;
  logic [A_W-1:0] fld_a;
  logic           ref_ok, div_ok;
  logic           ref_en, div_en;

  assign dest    = dest_e'(word_i[0]);
  assign fld_ref = word_i[R_W:1];
  assign fld_sw  = word_i[R_W+1];
  assign fld_a   = word_i[A_W:1];
  assign fld_n   = word_i[A_W+N_W:A_W+1];
  assign ref_ok  = (fld_ref >= R_MIN_V);
  assign div_ok  = (fld_n >= N_MIN_V);
  assign ref_en  = le_rise_i && (dest == DEST_REF) && ref_ok;
  assign div_en  = le_rise_i && (dest == DEST_DIV) && div_ok;

  always_comb begin
    ref_d = fld_ref;
    sw_d  = fld_sw;
    n_d   = fld_n;
    a_d   = fld_a;
    err_d = err_q;
    if (le_rise_i) begin
      if ((dest == DEST_REF) && !ref_ok) err_d = 1'b1;
      if ((dest == DEST_DIV) && !div_ok) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= R_MIN_V;
      sw_q  <= 1'b0;
      n_q   <= N_MIN_V;
      a_q   <= '0;
      err_q <= 1'b0;
    end else begin
      if (ref_en) begin
        ref_q <= ref_d;
        sw_q  <= sw_d;
      end
      if (div_en) begin
        n_q <= n_d;
        a_q <= a_d;
      end
      err_q <= err_d;
    end
  end

  assign ref_ratio_o = ref_q;
  assign pre_sel_o   = sw_q;
  assign main_cnt_o  = n_q;
  assign swallow_o   = a_q;
  assign cfg_err_o   = err_q;

  // R4: the reference latch never holds a ratio below the floor
  a_r4_ref_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_q >= R_MIN_V);
  // R5: the main counter latch never holds a ratio below the floor
  a_r5_main_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_q >= N_MIN_V);
  // R6: the error flag is sticky
  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  // R9: without a strobe edge nothing changes
  a_r9_hold_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !le_rise_i |=> ($stable(ref_q) && $stable(sw_q) && $stable(n_q) && $stable(a_q)));
  // R7: a reference load leaves the divider latch alone
  a_r7_ref_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_rise_i && word_i[0]) |=> ($stable(n_q) && $stable(a_q)));
  // R7: a divider load leaves the reference latch alone
  a_r7_div_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_rise_i && !word_i[0]) |=> ($stable(ref_q) && $stable(sw_q)));
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if #(
  parameter int unsigned R_W = 14,
  parameter int unsigned N_W = 11,
  parameter int unsigned A_W = 7,
  parameter int unsigned R_MIN = 8,
  parameter int unsigned N_MIN = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ser_data_i,
  input  logic           ser_clk_i,
  input  logic           ser_le_i,
  output logic [R_W-1:0] ref_ratio_o,
  output logic           pre_sel_o,
  output logic [N_W-1:0] main_cnt_o,
  output logic [A_W-1:0] swallow_o,
  output logic           cfg_err_o
);
  import sp_pkg::*;

  localparam int unsigned REF_WORD_W = R_W + 2;
  localparam int unsigned DIV_WORD_W = N_W + A_W + 1;
  localparam int unsigned WORD_W     = max2(REF_WORD_W, DIV_WORD_W);

  logic              rst_n_sync;
  logic [2:0]        pins_s;
  logic [WORD_W-1:0] word;
  logic              le_rise;

  sp_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_n_sync)
  );

  // Strobe resets high so an idle-high strobe gives no spurious load
  sp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n_sync),
    .d_i   ({ser_le_i, ser_clk_i, ser_data_i}),
    .q_o   (pins_s)
  );

  sp_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_sync),
    .bclk_s_i (pins_s[1]),
    .data_s_i (pins_s[0]),
    .le_s_i   (pins_s[2]),
    .word_o   (word),
    .le_rise_o(le_rise)
  );

  sp_cfg_bank #(
    .WORD_W(WORD_W), .R_W(R_W), .N_W(N_W), .A_W(A_W),
    .R_MIN(R_MIN), .N_MIN(N_MIN)
  ) u_cfg_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .word_i     (word),
    .le_rise_i  (le_rise),
    .ref_ratio_o(ref_ratio_o),
    .pre_sel_o  (pre_sel_o),
    .main_cnt_o (main_cnt_o),
    .swallow_o  (swallow_o),
    .cfg_err_o  (cfg_err_o)
  );
endmodule

// File: tb/synth_prog_if_tb.sv
module synth_prog_if_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_data = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_le = 1'b0;
  logic [13:0] ref_ratio;
  logic        pre_sel;
  logic [10:0] main_cnt;
  logic [6:0]  swallow;
  logic        cfg_err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  int exp_r, exp_sw, exp_n, exp_a, exp_err;

  always #5 clk = ~clk;

  synth_prog_if u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ser_data_i(ser_data), .ser_clk_i(ser_clk),
    .ser_le_i(ser_le), .ref_ratio_o(ref_ratio), .pre_sel_o(pre_sel),
    .main_cnt_o(main_cnt), .swallow_o(swallow), .cfg_err_o(cfg_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL R1 watchdog expired actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    @(negedge clk);
    chk(req, "ref_ratio", int'(ref_ratio), exp_r);
    chk(req, "pre_sel", int'(pre_sel), exp_sw);
    chk(req, "main_cnt", int'(main_cnt), exp_n);
    chk(req, "swallow", int'(swallow), exp_a);
    chk(req, "cfg_err", int'(cfg_err), exp_err);
  endtask

  function automatic logic [31:0] ref_word(input int sw, input int r);
    return {16'd0, 1'(sw), 14'(r), 1'b1};
  endfunction

  function automatic logic [31:0] div_word(input int n, input int a);
    return {13'd0, 11'(n), 7'(a), 1'b0};
  endfunction

  task automatic shift_bits(input logic [31:0] bits, input int len);
    for (int i = len - 1; i >= 0; i--) begin
      ser_data = bits[i];
      tick(3);
      ser_clk = 1'b1;
      tick(3);
      ser_clk = 1'b0;
      tick(2);
    end
  endtask

  task automatic pulse_le();
    ser_le = 1'b1;
    tick(6);
    ser_le = 1'b0;
    tick(6);
  endtask

  task automatic model_ref(input int sw, input int r);
    if (r < 8) exp_err = 1;
    else begin exp_r = r; exp_sw = sw; end
  endtask

  task automatic model_div(input int n, input int a);
    if (n < 16) exp_err = 1;
    else begin exp_n = n; exp_a = a; end
  endtask

  task automatic send_ref(input int sw, input int r);
    shift_bits(ref_word(sw, r), 16);
    pulse_le();
    model_ref(sw, r);
  endtask

  task automatic send_div(input int n, input int a);
    shift_bits(div_word(n, a), 19);
    pulse_le();
    model_div(n, a);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(6);
    exp_r = 8; exp_sw = 0; exp_n = 16; exp_a = 0; exp_err = 0;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset();
    check_all("R8");

    // R9: bit clock and data activity with the strobe low changes nothing
    shift_bits(32'h5A5A5A5A, 24);
    check_all("R9");

    // R2 and R4: exact floor is accepted, prescaler select set
    send_ref(1, 8);
    check_all("R4");
    send_ref(0, 16383);
    check_all("R2");
    // R3: divider fields
    send_div(2047, 127);
    check_all("R3");
    send_div(16, 0);
    check_all("R5");
    send_div(300, 45);
    check_all("R3");

    // R1: extra leading bits fall out of the register
    shift_bits(32'h7, 3);
    send_ref(1, 1234);
    check_all("R1");
    shift_bits(32'hF, 4);
    send_div(777, 99);
    check_all("R1");

    // R7: strobe held high while a new word is shifted in
    send_ref(0, 100);
    ser_le = 1'b1;
    tick(6);
    shift_bits(div_word(50, 3), 19);
    tick(4);
    check_all("R7");
    ser_le = 1'b0;
    tick(6);
    check_all("R7");
    pulse_le();
    model_div(50, 3);
    check_all("R7");

    // R4: ratio just below the floor is refused and flags an error
    send_ref(1, 7);
    check_all("R4");
    // R6: a later legal load keeps the flag
    send_ref(1, 500);
    check_all("R6");

    // R5: main ratio just below the floor is refused
    do_reset();
    send_div(15, 77);
    check_all("R5");
    send_div(40, 5);
    check_all("R6");

    // random mixture
    for (int it = 0; it < 40; it++) begin
      if (($urandom % 2) == 1) begin
        int r, sw;
        sw = int'($urandom % 2);
        r = ((($urandom % 6) == 0) ? int'($urandom % 8) : int'($urandom % 16384));
        send_ref(sw, r);
        check_all((r < 8) ? "R4" : "R2");
      end else begin
        int n, a;
        a = int'($urandom % 128);
        n = ((($urandom % 6) == 0) ? int'($urandom % 16) : int'($urandom % 2048));
        send_div(n, a);
        check_all((n < 16) ? "R5" : "R3");
      end
    end

    // R8: reset restores defaults and clears the flag
    do_reset();
    check_all("R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule